// File: doc/BRIEF.md
# In-DRAM Bulk Bitwise Command Sequencer

This block converts one bulk bitwise request (AND, OR or XOR of two source rows into a destination row) into the ordered stream of ACTIVATE and PRECHARGE commands that make a single DRAM bank compute the result inside the array. The operands are first copied into reserved scratch rows. A constant row of zeros or ones is then copied in beside them, so that a triple-row activation settles to the AND or the OR of the two operands by majority. XOR also passes each operand through an inverting row, which stores the complement of whatever is copied into it, and combines two partial products with a final OR.

Each copy step is two single-row ACTIVATEs followed by one PRECHARGE. Each majority step is one three-row ACTIVATE followed by one PRECHARGE. The block issues at most one command per cycle and waits the full ACTIVATE or PRECHARGE latency before the next one, because the bank can only serve one command at a time. The row numbers of the scratch, constant and inverting rows are parameters. A controller above this block presents a request while `busy` is low and waits for `done`.

Top module: `bitop_cmd_seq`

## Requirements
- R1: Opcode encoding on `req_op`: 2'b00 AND, 2'b01 OR, 2'b10 XOR. A request with `req_valid` high is taken on the clock edge where `busy` is low. The first command appears in the cycle after that edge and is a single-row ACTIVATE of `req_src_a`.
- R2: AND runs four copy steps and one majority step, using the all-zeros row: 14 commands, after which the destination row holds the bitwise AND of the sources.
- R3: OR runs the same step pattern but uses the all-ones row: 14 commands, after which the destination row holds the bitwise OR of the sources.
- R4: XOR runs eight copy steps and three majority steps, with the operand complements taken through the two inverting rows: 30 commands, after which the destination row holds the bitwise XOR of the sources.
- R5: Command encoding on `cmd_kind`: 2'b01 ACTIVATE, 2'b10 PRECHARGE, 2'b00 when idle. `cmd_nrows` is 1 or 3 for an ACTIVATE and 0 for a PRECHARGE. At most one of `cmd_valid`, `done` and `err` is high in any cycle.
- R6: The next command, or `done`, comes exactly ACT_LAT cycles after an ACTIVATE and exactly PRE_LAT cycles after a PRECHARGE. Both latencies must be at least 2.
- R7: `done` is high for one cycle, PRE_LAT cycles after the final PRECHARGE, so an operation lasts the sum of its command latencies counted from its first command. `busy` is high from the cycle after acceptance up to `done` and is low in the `done` cycle.
- R8: A request presented while `busy` is high is ignored. It issues no commands and writes no row.
- R9: Opcode 2'b11 is rejected. `err` is high for exactly one cycle after the edge that saw it, no command is issued and `busy` stays low.
- R10: A request presented in the cycle where `done` is high is accepted at once, and its first command follows in the next cycle.
- R11: After reset `cmd_valid`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | Operation code |
| req_dst | input | ROW_W | Destination row |
| req_src_a | input | ROW_W | First source row |
| req_src_b | input | ROW_W | Second source row |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_kind | output | 2 | ACTIVATE or PRECHARGE |
| cmd_nrows | output | 2 | Rows opened by an ACTIVATE |
| cmd_row0 | output | ROW_W | First row of the command |
| cmd_row1 | output | ROW_W | Second row (three-row ACTIVATE) |
| cmd_row2 | output | ROW_W | Third row (three-row ACTIVATE) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, one-cycle pulse |
| err | output | 1 | Unsupported opcode rejected |

## Verification
Two events can fall in the same cycle: the completion of one operation, signalled by `done`, and the arrival of the next request. The bench keeps `req_valid` raised in the very cycle where it observes `done`, so every operation after the first in the sweep starts back to back. It then checks that the first ACTIVATE appears in the following cycle and that the operation's result and timing are unchanged. Each result is judged against a behavioural row model fed only by the command port, which copies rows, complements rows copied into an inverting row and takes the majority on three-row activations. The expected values are the plain AND, OR and XOR of the source patterns.

// File: rtl/bitop_seq_pkg.sv
package bitop_seq_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_XOR = 2'b10,
        OP_BAD = 2'b11
    } bop_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_ACT  = 2'b01,
        CMD_PRE  = 2'b10
    } cmd_e;

    // symbolic row selectors resolved to addresses in the top
    typedef enum logic [3:0] {
        RS_SRCA, RS_SRCB, RS_DST,
        RS_T0, RS_T1, RS_T2,
        RS_ZERO, RS_ONE,
        RS_INV0, RS_INV1
    } rsel_e;

    typedef struct packed {
        logic  triple;
        rsel_e r0;
        rsel_e r1;
        rsel_e r2;
        logic  last;
    } step_t;

    localparam int STEP_IDX_W = 4;

endpackage

// File: rtl/bitop_script.sv
module bitop_script
    import bitop_seq_pkg::*;
(
    input  bop_e                  op,
    input  logic [STEP_IDX_W-1:0] idx,
    output step_t                 step
);

    function automatic step_t cp(rsel_e from, rsel_e to, logic fin);
        return '{triple: 1'b0, r0: from, r1: to, r2: RS_T2, last: fin};
    endfunction

    function automatic step_t mj(rsel_e a, rsel_e b, rsel_e c);
        return '{triple: 1'b1, r0: a, r1: b, r2: c, last: 1'b0};
    endfunction

    always_comb begin
        step = cp(RS_SRCA, RS_T0, 1'b0);
        if (op == OP_XOR) begin
            case (idx)
                4'd0:    step = cp(RS_SRCA, RS_T0, 1'b0);
                4'd1:    step = cp(RS_SRCB, RS_T1, 1'b0);
                4'd2:    step = cp(RS_SRCA, RS_INV0, 1'b0);
                4'd3:    step = cp(RS_SRCB, RS_INV1, 1'b0);
                4'd4:    step = cp(RS_ZERO, RS_T2, 1'b0);
                4'd5:    step = mj(RS_T0, RS_INV1, RS_T2);
                4'd6:    step = cp(RS_ZERO, RS_T2, 1'b0);
                4'd7:    step = mj(RS_T1, RS_INV0, RS_T2);
                4'd8:    step = cp(RS_ONE, RS_T2, 1'b0);
                4'd9:    step = mj(RS_T0, RS_T1, RS_T2);
                default: step = cp(RS_T0, RS_DST, 1'b1);
            endcase
        end else begin
            case (idx)
                4'd0:    step = cp(RS_SRCA, RS_T0, 1'b0);
                4'd1:    step = cp(RS_SRCB, RS_T1, 1'b0);
                4'd2:    step = cp((op == OP_OR) ? RS_ONE : RS_ZERO, RS_T2, 1'b0);
                4'd3:    step = mj(RS_T0, RS_T1, RS_T2);
                default: step = cp(RS_T0, RS_DST, 1'b1);
            endcase
        end
    end

endmodule

// File: rtl/bitop_lat_timer.sv
module bitop_lat_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R6: a new wait is only started once the previous one has elapsed
    a_r6_load_when_expired: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

endmodule

// File: rtl/bitop_cmd_seq.sv
module bitop_cmd_seq
    import bitop_seq_pkg::*;
#(
    parameter int ROW_W    = 16,
    parameter int ACT_LAT  = 50,
    parameter int PRE_LAT  = 20,
    parameter int ROW_T0   = 65520,
    parameter int ROW_T1   = 65521,
    parameter int ROW_T2   = 65522,
    parameter int ROW_ZERO = 65523,
    parameter int ROW_ONE  = 65524,
    parameter int ROW_INV0 = 65525,
    parameter int ROW_INV1 = 65526
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [ROW_W-1:0] req_dst,
    input  logic [ROW_W-1:0] req_src_a,
    input  logic [ROW_W-1:0] req_src_b,
    output logic             cmd_valid,
    output logic [1:0]       cmd_kind,
    output logic [1:0]       cmd_nrows,
    output logic [ROW_W-1:0] cmd_row0,
    output logic [ROW_W-1:0] cmd_row1,
    output logic [ROW_W-1:0] cmd_row2,
    output logic             busy,
    output logic             done,
    output logic             err
);

    localparam int MAX_LAT = (ACT_LAT > PRE_LAT) ? ACT_LAT : PRE_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic                  run;
        bop_e                  op;
        logic [STEP_IDX_W-1:0] idx;
        logic [1:0]            ph;
        logic                  fin;
        logic                  err;
        logic [ROW_W-1:0]      dst;
        logic [ROW_W-1:0]      sa;
        logic [ROW_W-1:0]      sb;
    } seq_t;

    seq_t             s_d, s_q;
    step_t            step;
    logic             t_idle;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             fire;
    logic             take;
    logic             is_act;

    bitop_script u_script (
        .op   (s_q.op),
        .idx  (s_q.idx),
        .step (step)
    );

    bitop_lat_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_idle)
    );

    function automatic logic [ROW_W-1:0] rowof(rsel_e s, logic [ROW_W-1:0] dst,
                                               logic [ROW_W-1:0] sa, logic [ROW_W-1:0] sb);
        case (s)
            RS_SRCA: return sa;
            RS_SRCB: return sb;
            RS_DST:  return dst;
            RS_T0:   return ROW_W'(ROW_T0);
            RS_T1:   return ROW_W'(ROW_T1);
            RS_T2:   return ROW_W'(ROW_T2);
            RS_ZERO: return ROW_W'(ROW_ZERO);
            RS_ONE:  return ROW_W'(ROW_ONE);
            RS_INV0: return ROW_W'(ROW_INV0);
            default: return ROW_W'(ROW_INV1);
        endcase
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        cmd_valid = 1'b0;
        cmd_kind  = CMD_NONE;
        cmd_nrows = 2'd0;
        cmd_row0  = '0;
        cmd_row1  = '0;
        cmd_row2  = '0;
        done      = 1'b0;
        t_load    = 1'b0;
        t_val     = '0;
        fire      = s_q.run && t_idle;
        is_act    = step.triple ? (s_q.ph == 2'd0) : (s_q.ph != 2'd2);

        if (fire && s_q.fin) begin
            done    = 1'b1;
            s_d.run = 1'b0;
        end else if (fire) begin
            cmd_valid = 1'b1;
            t_load    = 1'b1;
            if (is_act) begin
                cmd_kind = CMD_ACT;
                t_val    = CNT_W'(ACT_LAT - 1);
                s_d.ph   = s_q.ph + 2'd1;
                if (step.triple) begin
                    cmd_nrows = 2'd3;
                    cmd_row0  = rowof(step.r0, s_q.dst, s_q.sa, s_q.sb);
                    cmd_row1  = rowof(step.r1, s_q.dst, s_q.sa, s_q.sb);
                    cmd_row2  = rowof(step.r2, s_q.dst, s_q.sa, s_q.sb);
                end else begin
                    cmd_nrows = 2'd1;
                    cmd_row0  = rowof((s_q.ph == 2'd0) ? step.r0 : step.r1,
                                      s_q.dst, s_q.sa, s_q.sb);
                end
            end else begin
                cmd_kind = CMD_PRE;
                t_val    = CNT_W'(PRE_LAT - 1);
                s_d.ph   = 2'd0;
                if (step.last) s_d.fin = 1'b1;
                else           s_d.idx = s_q.idx + 1'b1;
            end
        end

        take = req_valid && (!s_q.run || done);
        if (take) begin
            if (bop_e'(req_op) == OP_BAD) begin
                s_d.err = 1'b1;
            end else begin
                s_d.run = 1'b1;
                s_d.op  = bop_e'(req_op);
                s_d.idx = '0;
                s_d.ph  = 2'd0;
                s_d.fin = 1'b0;
                s_d.dst = req_dst;
                s_d.sa  = req_src_a;
                s_d.sb  = req_src_b;
            end
        end

        busy = s_q.run && !done;
        err  = s_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r5_exclusive_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, done, err}));

    a_r5_pre_has_no_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_PRE) |-> (cmd_nrows == 2'd0));

    a_r6_no_adjacent_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!cmd_valid && !busy));

endmodule

// File: tb/bitop_cmd_seq_bench.sv
module bitop_cmd_seq_bench;

    localparam int RW   = 6;
    localparam int ALAT = 3;
    localparam int PLAT = 2;
    localparam int T0 = 48, T1 = 49, T2 = 50, ZR = 51, ON = 52, IV0 = 53, IV1 = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [RW-1:0] req_dst = '0, req_src_a = '0, req_src_b = '0;
    logic          cmd_valid, busy, done, err;
    logic [1:0]    cmd_kind, cmd_nrows;
    logic [RW-1:0] cmd_row0, cmd_row1, cmd_row2;

    always #4 clk = ~clk;

    bitop_cmd_seq #(
        .ROW_W(RW), .ACT_LAT(ALAT), .PRE_LAT(PLAT),
        .ROW_T0(T0), .ROW_T1(T1), .ROW_T2(T2), .ROW_ZERO(ZR), .ROW_ONE(ON),
        .ROW_INV0(IV0), .ROW_INV1(IV1)
    ) u_bitop_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_dst(req_dst), .req_src_a(req_src_a), .req_src_b(req_src_b),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_nrows(cmd_nrows),
        .cmd_row0(cmd_row0), .cmd_row1(cmd_row1), .cmd_row2(cmd_row2),
        .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0, n_bad = 0;
    bit reported = 1'b0;

    // behavioural row model, driven only from the command port
    logic [7:0]    va = 8'h00, vb = 8'h00;   // contents of source rows 1 and 2
    logic [7:0]    mem [64];
    logic [RW-1:0] first_row;
    bit            have_first, last_act;
    int            cyc, last_cyc, ncmd = 0, gaperr = 0;

    function automatic logic [7:0] rd(input logic [RW-1:0] r);
        if (r == 1)  return va;
        if (r == 2)  return vb;
        if (r == ZR) return 8'h00;
        if (r == ON) return 8'hFF;
        return mem[r];
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] = 8'hC3;
            have_first = 1'b0;
            last_act   = 1'b0;
            last_cyc   = -1;
            cyc        = 0;
        end else begin
            cyc++;
            if (cmd_valid) begin
                logic [7:0] v;
                ncmd++;
                if (last_cyc >= 0 && (cyc - last_cyc) != (last_act ? ALAT : PLAT)) gaperr++;
                last_cyc = cyc;
                last_act = (cmd_kind == 2'b01);
                if (cmd_kind == 2'b01 && cmd_nrows == 2'd3) begin
                    v = (rd(cmd_row0) & rd(cmd_row1)) | (rd(cmd_row0) & rd(cmd_row2))
                      | (rd(cmd_row1) & rd(cmd_row2));
                    mem[cmd_row0] = v;
                    mem[cmd_row1] = v;
                    mem[cmd_row2] = v;
                end else if (cmd_kind == 2'b01) begin
                    if (!have_first) begin
                        first_row  = cmd_row0;
                        have_first = 1'b1;
                    end else begin
                        v = rd(first_row);
                        mem[cmd_row0] = (cmd_row0 == IV0 || cmd_row0 == IV1) ? ~v : v;
                    end
                end else begin
                    have_first = 1'b0;
                end
            end
            if (done) begin
                if (last_act || (cyc - last_cyc) != PLAT) gaperr++;
                last_cyc = -1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    function automatic logic [7:0] pat(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h0F;
            3: return 8'h33;
            4: return 8'h55;
            default: return 8'hA6;
        endcase
    endfunction

    // called at posedge+2; b2b marks a start in a done cycle (R10)
    task automatic do_op(input int op, input logic [7:0] a, input logic [7:0] b,
                         input int dr, input bit b2b, input bit inject);
        int base, k, naap, ntrip, total;
        bit seen;
        logic [7:0] exp;
        va = a; vb = b;
        base = ncmd;
        req_valid = 1'b1; req_op = 2'(op);
        req_dst = RW'(dr); req_src_a = RW'(1); req_src_b = RW'(2);
        @(posedge clk); #2;
        req_valid = 1'b0;
        check(b2b ? "R10 first ACT after done-cycle start" : "R1 first ACT",
              {cmd_valid, cmd_kind, cmd_nrows, 2'b00, cmd_row0}, {1'b1, 2'b01, 2'd1, 2'b00, RW'(1)});
        check("R7 busy while running", busy, 1'b1);
        seen = 1'b0;
        k = 0;
        while (!seen && k < 3000) begin
            @(posedge clk); #2;
            k++;
            if (inject && k == 5) begin
                req_valid = 1'b1; req_op = 2'b10; req_dst = RW'(20);
            end else if (inject && k == 6) begin
                req_valid = 1'b0;
            end
            if (done) seen = 1'b1;
        end
        check("R7 done seen", seen, 1'b1);
        naap  = (op == 2) ? 8 : 4;
        ntrip = (op == 2) ? 3 : 1;
        total = (2 * naap + ntrip) * ALAT + (naap + ntrip) * PLAT;
        check("R7 duration", k, total);
        check("R7 busy low in done cycle", busy, 1'b0);
        exp = (op == 0) ? (a & b) : (op == 1) ? (a | b) : (a ^ b);
        if (op == 0) begin
            check("R2 AND command count", ncmd - base, 14);
            check("R2 AND result", mem[dr], exp);
        end else if (op == 1) begin
            check("R3 OR command count", ncmd - base, 14);
            check("R3 OR result", mem[dr], exp);
        end else begin
            check("R4 XOR command count", ncmd - base, 30);
            check("R4 XOR result", mem[dr], exp);
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int base;
        bit first;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        check("R11 cmd_valid after reset", cmd_valid, 1'b0);
        check("R11 busy after reset", busy, 1'b0);
        check("R11 done after reset", done, 1'b0);
        check("R11 err after reset", err, 1'b0);

        // unsupported opcode while idle
        base = ncmd;
        req_valid = 1'b1; req_op = 2'b11; req_dst = RW'(7);
        @(posedge clk); #2;
        req_valid = 1'b0;
        check("R9 err pulse", err, 1'b1);
        check("R9 stays idle", busy, 1'b0);
        check("R9 no command", cmd_valid, 1'b0);
        repeat (10) @(posedge clk);
        #2;
        check("R9 err cleared", err, 1'b0);
        check("R9 no commands issued", ncmd - base, 0);
        check("R9 no row written", mem[7], 8'hC3);

        // sweep of operand patterns and operations, mostly back to back
        first = 1'b1;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                for (int op = 0; op < 3; op++) begin
                    do_op(op, pat(i), pat(j), 3 + op, !first, 1'b0);
                    first = 1'b0;
                end
            end
        end

        // request while busy must be ignored
        do_op(0, 8'hA5, 8'h3C, 6, 1'b1, 1'b1);
        check("R8 ignored request wrote nothing", mem[20], 8'hC3);

        // rejected opcode presented in a done cycle
        req_valid = 1'b1; req_op = 2'b11;
        @(posedge clk); #2;
        req_valid = 1'b0;
        check("R9 err after done-cycle request", {err, busy}, 2'b10);

        check("R6 command and done spacing errors", gaperr, 0);
        summary();
    end

endmodule